// File: doc/BRIEF.md
# DDC Rate Snoop with Termination Control

This block listens, without ever driving, to the source-side SCL and SDA lines of a display data channel. It follows every I2C transaction aimed at one sink target and register offset. From the value of one bit seen at that location, it keeps a clock-ratio status flag that reports whether the link runs in its high-rate mode. A write of that bit sets or clears the flag, and a read that returns a 1 sets it.

The flag lives in an eight-bit control register that the local register port reads and writes. The register also holds a transmitter slew select, a termination mode, a DDC speed select and a snoop-disable bit. From the termination mode and the flag, the block resolves an effective termination choice. A hot-plug timer returns the flag to 0 once the sink's hot-plug signal has stayed low for longer than a set time (2 ms by default).

Top module: `ddc_rate_snoop`

## Requirements
- R1: After reset the register reads 0x50: slew select 01, termination mode 10, speed select 0, status 0 and disable 0. The effective termination is 00 (none) and clk_ratio_o is 0.
- R2: A write to 8-bit bus address 0xA8 whose data byte lands at offset 0x20 with bit 1 set makes the status 1. If the status was 0, the termination mode (register bits 4:3) is loaded with 11 at the same time.
- R3: Such a write with bit 1 clear makes the status 0 and leaves the termination mode unchanged.
- R4: A read at address 0xA9, after a repeated START that follows an offset write of 0x20, sets the status when the returned byte has bit 1 set. A read that returns 0 in bit 1 leaves the status unchanged.
- R5: The first data byte after a write address loads the offset pointer, and every later data byte in the same burst advances the pointer by one. A burst that starts at offset 0x1F therefore tracks its second data byte.
- R6: Transactions to other bus addresses, or to other offsets, leave the register unchanged.
- R7: A register write that changes disable (bit 0) from 0 to 1 clears the status, whatever value is written to bit 1. While disable is 1, bus traffic has no effect on the register.
- R8: A register write with disable already at 1 sets the status from bit 1 of the written data.
- R9: When the hot-plug input stays low longer than the timeout, the status becomes 0 and is held at 0 until hot-plug returns high. A shorter low period has no effect.
- R10: term_sel_o decodes the termination mode as follows: 00 gives 01 (high-ohm range), 01 gives 00 (none), 10 gives 10 (low-ohm range) when the status is 1 and 00 when it is 0, and 11 gives 10.
- R11: A register write stores slew select (bits 7:6), termination mode and speed select (bit 2). These appear on slew_sel_o and ddc_fast_o. Bit 5 always reads 0.
- R12: Pulses on SCL or SDA that last fewer than FILT_CYC clocks are ignored. A one-clock SDA pulse while SCL is high does not break a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Observed DDC clock line |
| sda_i | input | 1 | Observed DDC data line |
| hpd_i | input | 1 | Hot-plug detect from the sink |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| slew_sel_o | output | 2 | Slew select field |
| ddc_fast_o | output | 1 | DDC speed select (1 = 400 kbps) |
| term_sel_o | output | 2 | Effective termination: 00 none, 01 high-ohm, 10 low-ohm |
| clk_ratio_o | output | 1 | Clock-ratio status flag |

## Verification
The hardest case to reach from the ports is a tracked read. The status must then come from a byte that the sink drives, and the offset must come from an earlier write that is separated from the read by a repeated START. The bench's bus driver writes offset 0x20, issues a repeated START, sends address 0xA9 and then drives the data bits itself while acting as the sink. This is done once with bit 1 set and once with it clear. The hot-plug window is reached by shrinking the clock-frequency parameter so that the timeout is a few thousand cycles, and the status is checked just before and just after that point.

// File: rtl/ddc_snoop_pkg.sv
package ddc_snoop_pkg;

   // bus location being watched
   localparam logic [6:0] WATCH_ADDR7 = 7'h54;   // 0xA8 write, 0xA9 read
   localparam logic [7:0] WATCH_OFS   = 8'h20;
   localparam int         WATCH_BIT   = 1;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } bus_phase_t;

   typedef enum logic [1:0] {
      TERM_NONE = 2'b00,
      TERM_HIGH = 2'b01,
      TERM_LOW  = 2'b10
   } term_t;

   // termination mode field encodings
   localparam logic [1:0] TMODE_HIGH   = 2'b00;
   localparam logic [1:0] TMODE_NONE   = 2'b01;
   localparam logic [1:0] TMODE_FOLLOW = 2'b10;
   localparam logic [1:0] TMODE_LOW    = 2'b11;

   function automatic term_t resolve_term(input logic [1:0] mode, input logic ratio);
      case (mode)
         TMODE_HIGH:   return TERM_HIGH;
         TMODE_NONE:   return TERM_NONE;
         TMODE_FOLLOW: return ratio ? TERM_LOW : TERM_NONE;
         default:      return TERM_LOW;
      endcase
   endfunction

endpackage

// File: rtl/ddc_line_filter.sv
module ddc_line_filter #(
   parameter int FILT_CYC = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic line_i,
   output logic line_o
);
   localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);

   logic s1_q, s2_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         s1_q <= 1'b1;
         s2_q <= 1'b1;
      end else begin
         s1_q <= line_i;
         s2_q <= s1_q;
      end
   end

   generate
      if (FILT_CYC == 0) begin : g_nofilt
         assign line_o = s2_q;
      end else begin : g_filt
         logic          out_q;
         logic [CW-1:0] run_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               out_q <= 1'b1;
               run_q <= '0;
            end else if (s2_q == out_q) begin
               run_q <= '0;
            end else if (run_q == CW'(FILT_CYC - 1)) begin
               out_q <= s2_q;
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign line_o = out_q;

         // R12
         filt_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (out_q != $past(out_q)) |-> ($past(s2_q) == out_q));
      end
   endgenerate

endmodule

// File: rtl/ddc_bus_tracker.sv
module ddc_bus_tracker
   import ddc_snoop_pkg::*;
#(
   parameter logic [6:0] ADDR7   = WATCH_ADDR7,
   parameter logic [7:0] OFFSET  = WATCH_OFS,
   parameter int         BIT_POS = WATCH_BIT
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic scl_i,
   input  logic sda_i,
   output logic hit_set_o,
   output logic hit_clr_o
);
   logic       scl_d, sda_d;
   logic       start_w, stop_w, rise_w;
   bus_phase_t ph_q;
   logic [3:0] cnt_q;
   logic [7:0] sh_q;
   logic [7:0] ptr_q;
   logic       match_q, read_q, want_ofs_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_i;
         sda_d <= sda_i;
      end
   end

   assign start_w = scl_i && scl_d && sda_d && !sda_i;
   assign stop_w  = scl_i && scl_d && !sda_d && sda_i;
   assign rise_w  = scl_i && !scl_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q       <= PH_IDLE;
         cnt_q      <= '0;
         sh_q       <= '0;
         ptr_q      <= '0;
         match_q    <= 1'b0;
         read_q     <= 1'b0;
         want_ofs_q <= 1'b0;
         hit_set_o  <= 1'b0;
         hit_clr_o  <= 1'b0;
      end else begin
         hit_set_o <= 1'b0;
         hit_clr_o <= 1'b0;
         if (start_w) begin
            ph_q  <= PH_ADDR;
            cnt_q <= '0;
         end else if (stop_w) begin
            ph_q <= PH_IDLE;
         end else if (rise_w && ph_q != PH_IDLE) begin
            if (cnt_q != 4'd8) begin
               sh_q  <= {sh_q[6:0], sda_i};
               cnt_q <= cnt_q + 4'd1;
            end else begin
               cnt_q <= '0;
               if (ph_q == PH_ADDR) begin
                  ph_q       <= PH_DATA;
                  match_q    <= (sh_q[7:1] == ADDR7) && !sda_i;
                  read_q     <= sh_q[0];
                  want_ofs_q <= !sh_q[0];
               end else if (match_q) begin
                  if (want_ofs_q) begin
                     ptr_q      <= sh_q;
                     want_ofs_q <= 1'b0;
                  end else begin
                     if (ptr_q == OFFSET) begin
                        if (sh_q[BIT_POS])  hit_set_o <= 1'b1;
                        else if (!read_q)   hit_clr_o <= 1'b1;
                     end
                     ptr_q <= ptr_q + 8'd1;
                  end
               end
            end
         end
      end
   end

   // R5
   start_resets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_w |=> (ph_q == PH_ADDR && cnt_q == 4'd0));

   // R4
   read_never_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (read_q && ph_q == PH_DATA && !start_w) |=> !hit_clr_o);

endmodule

// File: rtl/ddc_hpd_timer.sv
module ddc_hpd_timer #(
   parameter int CLK_HZ     = 100_000_000,
   parameter int HPD_LOW_US = 2000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic hpd_i,
   output logic expired_o
);
   localparam int LIMIT = (CLK_HZ / 1000) * HPD_LOW_US / 1000;
   localparam int TW    = $clog2(LIMIT + 1);

   logic          h1_q, h2_q;
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         h1_q  <= 1'b0;
         h2_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         h1_q <= hpd_i;
         h2_q <= h1_q;
         if (h2_q)                       cnt_q <= '0;
         else if (cnt_q != TW'(LIMIT))   cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = !h2_q && (cnt_q == TW'(LIMIT));

   // R9
   hpd_high_rearms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      h2_q |=> !expired_o);

endmodule

// File: rtl/ddc_rate_snoop.sv
module ddc_rate_snoop
   import ddc_snoop_pkg::*;
#(
   parameter int CLK_HZ     = 100_000_000,
   parameter int HPD_LOW_US = 2000,
   parameter int FILT_CYC   = 3
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       hpd_i,
   input  logic       reg_wr_i,
   input  logic [7:0] reg_wdata_i,
   output logic [7:0] reg_rdata_o,
   output logic [1:0] slew_sel_o,
   output logic       ddc_fast_o,
   output logic [1:0] term_sel_o,
   output logic       clk_ratio_o
);
   generate
      if (FILT_CYC > 15) begin : g_bad_filt
         $error("FILT_CYC too large for the bus timing");
      end
      if (CLK_HZ < 1000) begin : g_bad_clk
         $error("CLK_HZ must be at least 1 kHz");
      end
   endgenerate

   logic scl_f, sda_f;
   logic snoop_set, snoop_clr, hpd_exp;

   ddc_line_filter #(.FILT_CYC(FILT_CYC)) i_scl_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));
   ddc_line_filter #(.FILT_CYC(FILT_CYC)) i_sda_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

   ddc_bus_tracker i_tracker (
      .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
      .hit_set_o(snoop_set), .hit_clr_o(snoop_clr));

   ddc_hpd_timer #(.CLK_HZ(CLK_HZ), .HPD_LOW_US(HPD_LOW_US)) i_hpd (
      .clk_i(clk_i), .rst_ni(rst_ni), .hpd_i(hpd_i), .expired_o(hpd_exp));

   logic [1:0] slew_q, tmode_q;
   logic       fast_q, ratio_q, dis_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         slew_q  <= 2'b01;
         tmode_q <= TMODE_FOLLOW;
         fast_q  <= 1'b0;
         ratio_q <= 1'b0;
         dis_q   <= 1'b0;
      end else begin
         if (reg_wr_i) begin
            slew_q  <= reg_wdata_i[7:6];
            tmode_q <= reg_wdata_i[4:3];
            fast_q  <= reg_wdata_i[2];
            dis_q   <= reg_wdata_i[0];
            ratio_q <= (reg_wdata_i[0] && !dis_q) ? 1'b0 : reg_wdata_i[1];
         end else if (!dis_q && !hpd_exp) begin
            if (snoop_set) begin
               ratio_q <= 1'b1;
               if (!ratio_q) tmode_q <= TMODE_LOW;
            end else if (snoop_clr) begin
               ratio_q <= 1'b0;
            end
         end
         if (hpd_exp) ratio_q <= 1'b0;
      end
   end

   assign reg_rdata_o = {slew_q, 1'b0, tmode_q, fast_q, ratio_q, dis_q};
   assign slew_sel_o  = slew_q;
   assign ddc_fast_o  = fast_q;
   assign clk_ratio_o = ratio_q;
   assign term_sel_o  = resolve_term(tmode_q, ratio_q);

   // R7
   disabled_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dis_q && !reg_wr_i) |=> !$rose(ratio_q));

   // R9
   hpd_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hpd_exp |=> !ratio_q);

   // R2
   snoop_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snoop_set && !dis_q && !reg_wr_i && !hpd_exp && !ratio_q)
         |=> (ratio_q && tmode_q == TMODE_LOW));

   // R3
   snoop_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (snoop_clr && !dis_q && !reg_wr_i) |=> (!ratio_q && $stable(tmode_q)));

endmodule

// File: tb/test_ddc_rate_snoop.sv
module test_ddc_rate_snoop;
   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1, hpd = 1'b1;
   logic       reg_wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [1:0] slew, term;
   logic       fast, ratio;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ddc_rate_snoop #(.CLK_HZ(1_000_000), .HPD_LOW_US(2000), .FILT_CYC(3)) i_ddc_rate_snoop (
      .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .hpd_i(hpd),
      .reg_wr_i(reg_wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .slew_sel_o(slew), .ddc_fast_o(fast), .term_sel_o(term), .clk_ratio_o(ratio));

   typedef struct {
      string      req;
      logic [7:0] rd;
      logic [1:0] tm;
   } item_t;
   item_t sb[$];

   // monitor: pops expected items and compares them with the ports
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         item_t it;
         it = sb.pop_front();
         checks++;
         if (rdata !== it.rd || term !== it.tm || slew !== it.rd[7:6] ||
             fast !== it.rd[2] || ratio !== it.rd[1]) begin
            errors++;
            $display("FAIL %s: rdata=%h term=%b slew=%b fast=%b ratio=%b expected rdata=%h term=%b",
                     it.req, rdata, term, slew, fast, ratio, it.rd, it.tm);
         end
      end
   end

   task automatic expect_state(input string req, input logic [7:0] rd, input logic [1:0] tm);
      item_t it;
      it.req = req; it.rd = rd; it.tm = tm;
      sb.push_back(it);
      @(negedge clk); #1;
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [7:0] v);
      @(negedge clk);
      reg_wr = 1'b1; wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
      wq(2);
   endtask

   task automatic bus_start;
      sda = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic bus_stop;
      sda = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda = 1'b1; wq(2*Q);
   endtask

   task automatic bus_bit(input logic b, input bit glitch);
      sda = b; wq(Q); scl = 1'b1; wq(Q);
      if (glitch && !b) begin sda = 1'b1; wq(1); sda = 1'b0; end
      wq(Q); scl = 1'b0; wq(Q);
   endtask

   task automatic bus_byte(input logic [7:0] v, input logic ackbit, input bit glitch);
      for (int i = 7; i >= 0; i--) bus_bit(v[i], glitch);
      bus_bit(ackbit, 1'b0);
   endtask

   task automatic wr_txn(input logic [7:0] a, input logic [7:0] ofs, input logic [7:0] d);
      bus_start; bus_byte(a, 1'b0, 1'b0); bus_byte(ofs, 1'b0, 1'b0);
      bus_byte(d, 1'b0, 1'b0); bus_stop;
   endtask

   task automatic rd_txn(input logic [7:0] ofs, input logic [7:0] d);
      bus_start; bus_byte(8'hA8, 1'b0, 1'b0); bus_byte(ofs, 1'b0, 1'b0);
      bus_start; bus_byte(8'hA9, 1'b0, 1'b0); bus_byte(d, 1'b1, 1'b0); bus_stop;
   endtask

   initial begin
      wq(4); rst_n = 1'b1; wq(4);
      // R1 reset value, R10 follow mode with status 0
      expect_state("R1", 8'h50, 2'b00);

      wr_txn(8'hA8, 8'h20, 8'h02);
      expect_state("R2", 8'h5A, 2'b10);
      wr_txn(8'hA8, 8'h20, 8'h00);
      expect_state("R3", 8'h58, 2'b10);

      reg_write(8'h50);
      expect_state("R11", 8'h50, 2'b00);
      wr_txn(8'hA0, 8'h20, 8'h02);
      expect_state("R6", 8'h50, 2'b00);
      wr_txn(8'hA8, 8'h21, 8'h02);
      expect_state("R6", 8'h50, 2'b00);

      // R5 burst from 0x1F: second data byte lands at 0x20
      bus_start; bus_byte(8'hA8, 1'b0, 1'b0); bus_byte(8'h1F, 1'b0, 1'b0);
      bus_byte(8'h00, 1'b0, 1'b0); bus_byte(8'h02, 1'b0, 1'b0); bus_stop;
      expect_state("R5", 8'h5A, 2'b10);

      reg_write(8'h50);
      expect_state("R10", 8'h50, 2'b00);
      rd_txn(8'h20, 8'h02);
      expect_state("R4", 8'h5A, 2'b10);
      reg_write(8'h50);
      rd_txn(8'h20, 8'h00);
      expect_state("R4", 8'h50, 2'b00);

      // R12 one-clock SDA pulses while SCL high must be filtered out
      bus_start; bus_byte(8'hA8, 1'b0, 1'b1); bus_byte(8'h20, 1'b0, 1'b1);
      bus_byte(8'h02, 1'b0, 1'b1); bus_stop;
      expect_state("R12", 8'h5A, 2'b10);

      // R7 disable 0->1 clears status even with bit 1 written
      reg_write(8'h53);
      expect_state("R7", 8'h51, 2'b00);
      wr_txn(8'hA8, 8'h20, 8'h02);
      expect_state("R7", 8'h51, 2'b00);
      reg_write(8'h53);
      expect_state("R8", 8'h53, 2'b10);

      reg_write(8'hE4);
      expect_state("R11", 8'hC4, 2'b01);
      reg_write(8'h48);
      expect_state("R10", 8'h48, 2'b00);

      // R9 hot-plug timeout
      reg_write(8'h50);
      wr_txn(8'hA8, 8'h20, 8'h02);
      expect_state("R2", 8'h5A, 2'b10);
      hpd = 1'b0; wq(500); hpd = 1'b1; wq(10);
      expect_state("R9", 8'h5A, 2'b10);
      hpd = 1'b0; wq(1900);
      expect_state("R9", 8'h5A, 2'b10);
      wq(200);
      expect_state("R9", 8'h58, 2'b10);
      wr_txn(8'hA8, 8'h20, 8'h02);
      expect_state("R9", 8'h58, 2'b10);
      hpd = 1'b1; wq(10);
      reg_write(8'h50);
      wr_txn(8'hA8, 8'h20, 8'h02);
      expect_state("R9", 8'h5A, 2'b10);

      wq(4);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule